// File: doc/BRIEF.md
# DMA Channel Enable Control Register

This block is the 64-bit control register through which software starts, pauses and kills the channels of an eight-channel DMA engine. Each channel has three control bits: an enable, a suspend request and an abort request. Each bit has a paired write-enable bit in the same word. A software write updates a control bit only when its paired write-enable is 1 in that same write. Every other bit keeps its value, so software can change one channel without a read-modify-write. The write-enable bits are never stored.

The channel engines feed events back: end of transfer, suspended status and aborted status. These events clear the matching bits in hardware. Hardware also clears bits when a channel is aborted or disabled. A global controller enable input gates the register. While it is low, the register is held at zero, writes are ignored and reads return zero. The registered vectors drive the channel engines directly, and the read port returns them with no wait cycles.

Top module: `dma_chan_ctl`

## Requirements
- R1: While rst_ni is low, every enable, suspend and abort bit is 0. Reads then return 0.
- R2: A write sets channel n's enable to wr_data_i[n] only if wr_data_i[8+n] is 1. With that bit at 0, the enable keeps its value whatever wr_data_i[n] holds.
- R3: A write sets channel n's suspend to wr_data_i[16+n] only if wr_data_i[24+n] is 1.
- R4: A write sets channel n's abort to wr_data_i[32+n] only if wr_data_i[40+n] is 1.
- R5: The read word has the enables in [7:0], the suspends in [23:16] and the aborts in [39:32]. All other positions read 0, including every write-enable position and bits [63:48].
- R6: While glb_en_i is 0, rd_data_o is 0 in the same cycle. At the next clock edge every bit clears, and writes have no effect.
- R7: xfer_done_i[n] clears channel n's enable at the next edge. The clear wins over a software write of 1 in the same cycle.
- R8: abort_ack_i[n] clears channel n's abort bit at the next edge. The clear wins over a software write of 1 in the same cycle.
- R9: At any edge where a channel's abort bit becomes or stays 1, its enable becomes 0. Enable and abort are never both 1 for a channel.
- R10: A suspend bit is held at 0 whenever its channel's enable is 0. Disabling a channel clears its suspend bit at the same edge, and suspend cannot be set on a disabled channel.
- R11: A software write of 0 to a set suspend bit takes effect only if susp_ack_i[n] is 1 in that cycle. Otherwise the suspend bit stays 1.
- R12: ch_en_o, ch_susp_o and ch_abort_o are the stored bit vectors, bit n for channel n. They match the corresponding read fields whenever glb_en_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global controller enable |
| wr_en_i | input | 1 | Address-decoded write strobe for this register |
| wr_data_i | input | 64 | Write data |
| rd_data_o | output | 64 | Read data, combinational |
| xfer_done_i | input | 8 | Per-channel last destination transfer completed |
| susp_ack_i | input | 8 | Per-channel suspended status |
| abort_ack_i | input | 8 | Per-channel aborted status |
| ch_en_o | output | 8 | Per-channel enable to the engines |
| ch_susp_o | output | 8 | Per-channel suspend request |
| ch_abort_o | output | 8 | Per-channel abort request |

## Verification
A wrong next-state term in any channel slice shows on that channel's output bit and on rd_data_o at the first edge after the triggering write or event. The bench therefore compares every output against a model after every edge. It also compares rd_data_o just after each input change, which exposes a missing global gate within the same cycle. The randomized events overlap software writes on the same bits, so the priority between hardware clears and software writes is tested repeatedly. The pairing between enable, abort and suspend is exercised the same way.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned REG_W     = 64;
  localparam int unsigned FIELD_W   = 8;   // pitch of every field, caps channel count
  localparam int unsigned EN_OFS    = 0;
  localparam int unsigned SUSP_OFS  = 16;
  localparam int unsigned ABORT_OFS = 32;
  localparam int unsigned WE_GAP    = FIELD_W;  // write-enable sits one field above its data

  typedef struct packed {
    logic en;
    logic susp;
    logic abort;
  } ch_ctl_t;
endpackage

// File: rtl/dma_chan_slice.sv
module dma_chan_slice
  import dma_chan_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    glb_en_i,
  input  logic    wr_sel_i,
  input  ch_ctl_t wr_val_i,
  input  ch_ctl_t wr_we_i,
  input  logic    xfer_done_i,
  input  logic    susp_ack_i,
  input  logic    abort_ack_i,
  output ch_ctl_t state_o
);
  ch_ctl_t q, d;
  logic    en_sw, su_sw, ab_sw;

  always_comb begin
    ab_sw = (wr_sel_i && wr_we_i.abort) ? wr_val_i.abort : q.abort;
    en_sw = (wr_sel_i && wr_we_i.en)    ? wr_val_i.en    : q.en;
    su_sw = q.susp;
    if (wr_sel_i && wr_we_i.susp) begin
      if (wr_val_i.susp)  su_sw = 1'b1;
      else if (susp_ack_i) su_sw = 1'b0;  // release only once suspended
    end
    // hardware clears take priority over software
    d.abort = glb_en_i & ab_sw & ~abort_ack_i;
    d.en    = glb_en_i & en_sw & ~xfer_done_i & ~d.abort;
    d.susp  = glb_en_i & su_sw & d.en;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign state_o = q;
endmodule

// File: rtl/dma_chan_rdmux.sv
module dma_chan_rdmux
  import dma_chan_pkg::*;
#(
  parameter int unsigned N_CH = 8
) (
  input  logic             glb_en_i,
  input  logic [N_CH-1:0]  en_i,
  input  logic [N_CH-1:0]  susp_i,
  input  logic [N_CH-1:0]  abort_i,
  output logic [REG_W-1:0] rd_data_o
);
  logic [REG_W-1:0] word;

  always_comb begin
    word = '0;
    word[EN_OFS    +: N_CH] = en_i;
    word[SUSP_OFS  +: N_CH] = susp_i;
    word[ABORT_OFS +: N_CH] = abort_i;
  end

  assign rd_data_o = glb_en_i ? word : '0;
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int unsigned N_CH = 8  // must not exceed FIELD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             glb_en_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic [N_CH-1:0]  xfer_done_i,
  input  logic [N_CH-1:0]  susp_ack_i,
  input  logic [N_CH-1:0]  abort_ack_i,
  output logic [N_CH-1:0]  ch_en_o,
  output logic [N_CH-1:0]  ch_susp_o,
  output logic [N_CH-1:0]  ch_abort_o
);
  logic wr_sel;
  assign wr_sel = wr_en_i & glb_en_i;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    ch_ctl_t val, we, st;
    assign val.en    = wr_data_i[EN_OFS + i];
    assign val.susp  = wr_data_i[SUSP_OFS + i];
    assign val.abort = wr_data_i[ABORT_OFS + i];
    assign we.en     = wr_data_i[EN_OFS + WE_GAP + i];
    assign we.susp   = wr_data_i[SUSP_OFS + WE_GAP + i];
    assign we.abort  = wr_data_i[ABORT_OFS + WE_GAP + i];

    dma_chan_slice u_slice (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .glb_en_i    (glb_en_i),
      .wr_sel_i    (wr_sel),
      .wr_val_i    (val),
      .wr_we_i     (we),
      .xfer_done_i (xfer_done_i[i]),
      .susp_ack_i  (susp_ack_i[i]),
      .abort_ack_i (abort_ack_i[i]),
      .state_o     (st)
    );

    assign ch_en_o[i]    = st.en;
    assign ch_susp_o[i]  = st.susp;
    assign ch_abort_o[i] = st.abort;
  end

  dma_chan_rdmux #(.N_CH(N_CH)) u_rdmux (
    .glb_en_i  (glb_en_i),
    .en_i      (ch_en_o),
    .susp_i    (ch_susp_o),
    .abort_i   (ch_abort_o),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk
  import dma_chan_pkg::*;
#(
  parameter int unsigned N_CH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             glb_en_i,
  input logic             wr_en_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic [N_CH-1:0]  xfer_done_i,
  input logic [N_CH-1:0]  susp_ack_i,
  input logic [N_CH-1:0]  abort_ack_i,
  input logic [N_CH-1:0]  ch_en_o,
  input logic [N_CH-1:0]  ch_susp_o,
  input logic [N_CH-1:0]  ch_abort_o
);
  a_r2_en_no_rise_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (ch_en_o & ~$past(ch_en_o)) == '0);

  a_r4_abort_no_rise_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (ch_abort_o & ~$past(ch_abort_o)) == '0);

  a_r5_unused_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[15:8] == '0 && rd_data_o[31:24] == '0 && rd_data_o[63:40] == '0);

  a_r6_read_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |-> rd_data_o == '0);

  a_r6_off_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |=> (ch_en_o | ch_susp_o | ch_abort_o) == '0);

  a_r7_done_clears_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|xfer_done_i) |=> (ch_en_o & $past(xfer_done_i)) == '0);

  a_r8_ack_clears_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|abort_ack_i) |=> (ch_abort_o & $past(abort_ack_i)) == '0);

  a_r9_abort_excludes_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_en_o & ch_abort_o) == '0);

  a_r10_susp_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_susp_o & ~ch_en_o) == '0);

  a_r11_susp_release_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($past(ch_susp_o) & ~ch_susp_o & ch_en_o & ~$past(susp_ack_i)) == '0);

  a_r12_outputs_match_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_en_i |-> rd_data_o[N_CH-1:0] == ch_en_o && rd_data_o[16 +: N_CH] == ch_susp_o
                 && rd_data_o[32 +: N_CH] == ch_abort_o);
endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.N_CH(N_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .glb_en_i    (glb_en_i),
  .wr_en_i     (wr_en_i),
  .rd_data_o   (rd_data_o),
  .xfer_done_i (xfer_done_i),
  .susp_ack_i  (susp_ack_i),
  .abort_ack_i (abort_ack_i),
  .ch_en_o     (ch_en_o),
  .ch_susp_o   (ch_susp_o),
  .ch_abort_o  (ch_abort_o)
);

// File: tb/dma_chan_ctl_tb_top.sv
module dma_chan_ctl_tb_top;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          glb_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [63:0]   wr_data = '0;
  logic [63:0]   rd_data;
  logic [N-1:0]  done = '0, sack = '0, aack = '0;
  logic [N-1:0]  en_o, su_o, ab_o;
  logic [N-1:0]  m_en = '0, m_su = '0, m_ab = '0;
  int            n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  dma_chan_ctl #(.N_CH(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb_en), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .xfer_done_i(done),
    .susp_ack_i(sack), .abort_ack_i(aack), .ch_en_o(en_o),
    .ch_susp_o(su_o), .ch_abort_o(ab_o)
  );

  function automatic logic [63:0] exp_read(input logic g, input logic [N-1:0] e, s, a);
    logic [63:0] w = '0;
    w[0 +: N]  = e;
    w[16 +: N] = s;
    w[32 +: N] = a;
    return g ? w : 64'h0;
  endfunction

  // next model state {abort, susp, en} from the requirements
  function automatic logic [3*N-1:0] exp_next(input logic g, wr, input logic [63:0] d,
      input logic [N-1:0] dn, sk, ak, e, s, a);
    logic [N-1:0] ne, ns, na;
    for (int i = 0; i < N; i++) begin
      logic ab, en, su;
      ab = (wr && d[40+i]) ? d[32+i] : a[i];
      en = (wr && d[8+i])  ? d[i]    : e[i];
      su = s[i];
      if (wr && d[24+i]) su = d[16+i] ? 1'b1 : (sk[i] ? 1'b0 : s[i]);
      na[i] = g & ab & ~ak[i];
      ne[i] = g & en & ~dn[i] & ~na[i];
      ns[i] = g & su & ne[i];
    end
    return {na, ns, ne};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic g, wr, input logic [63:0] d,
                      input logic [N-1:0] dn, sk, ak);
    logic [3*N-1:0] nx;
    @(negedge clk);
    glb_en = g; wr_en = wr; wr_data = d; done = dn; sack = sk; aack = ak;
    #1;
    chk({tag, " comb read"}, rd_data, exp_read(g, m_en, m_su, m_ab));
    nx = exp_next(g, wr, d, dn, sk, ak, m_en, m_su, m_ab);
    @(posedge clk);
    #1;
    {m_ab, m_su, m_en} = nx;
    chk({tag, " en"},    64'(en_o), 64'(m_en));
    chk({tag, " susp"},  64'(su_o), 64'(m_su));
    chk({tag, " abort"}, 64'(ab_o), 64'(m_ab));
    chk({tag, " read"},  rd_data, exp_read(g, m_en, m_su, m_ab));
  endtask

  task automatic wr(input string tag, input logic [63:0] d);
    step(tag, 1'b1, 1'b1, d, '0, '0, '0);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    chk("R1 reset read", rd_data, 64'h0);
    chk("R1 reset outs", {40'h0, en_o, su_o, ab_o}, 64'h0);
    rst_n = 1'b1;
    glb_en = 1'b1;
    @(negedge clk);

    wr("R2 set en0", 64'h0000_0000_0000_0101);
    chk("R2 en0 only", 64'(en_o), 64'h01);
    wr("R2 no we", 64'h0000_0000_0000_00FE);
    chk("R2 unchanged", 64'(en_o), 64'h01);
    wr("R3 set susp0", 64'h0000_0000_0101_0000);
    chk("R3 susp0", 64'(su_o), 64'h01);
    wr("R10 susp on disabled", 64'h0000_0000_0202_0000);
    chk("R10 susp1 held 0", 64'(su_o), 64'h01);
    wr("R11 clear no ack", 64'h0000_0000_0100_0000);
    chk("R11 susp kept", 64'(su_o), 64'h01);
    step("R11 clear ack", 1'b1, 1'b1, 64'h0000_0000_0100_0000, '0, 8'h01, '0);
    chk("R11 susp released", 64'(su_o), 64'h00);
    wr("R3 resuspend", 64'h0000_0000_0101_0000);
    wr("R10 disable", 64'h0000_0000_0000_0100);
    chk("R10 en0 off", 64'(en_o), 64'h00);
    chk("R10 susp cleared", 64'(su_o), 64'h00);
    wr("R2 en2 en3", 64'h0000_0000_0000_0C0C);
    wr("R4 abort2", 64'h0000_0404_0000_0000);
    chk("R4 abort2 set", 64'(ab_o), 64'h04);
    chk("R9 en2 dropped", 64'(en_o), 64'h08);
    step("R8 ack2", 1'b1, 1'b0, 64'h0, '0, '0, 8'h04);
    chk("R8 abort2 cleared", 64'(ab_o), 64'h00);
    step("R8 ack wins", 1'b1, 1'b1, 64'h0000_2020_0000_0000, '0, '0, 8'h20);
    chk("R8 abort5 not set", 64'(ab_o), 64'h00);
    step("R7 done wins", 1'b1, 1'b1, 64'h0000_0000_0000_1818, 8'h08, '0, '0);
    chk("R7 en3 cleared en4 set", 64'(en_o), 64'h10);
    wr("R5 all fields", 64'hFFFF_00FF_FFFF_FFFF);
    chk("R5 read layout", rd_data, 64'h0000_0000_00FF_00FF);
    step("R6 off", 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, '0, '0, '0);
    chk("R6 cleared", {40'h0, en_o, su_o, ab_o}, 64'h0);
    step("R6 off write", 1'b0, 1'b1, 64'h0000_0000_0000_FFFF, '0, '0, '0);
    step("R6 back on", 1'b1, 1'b0, 64'h0, '0, '0, '0);
    chk("R6 stayed zero", rd_data, 64'h0);

    for (int k = 0; k < 4000; k++) begin
      logic [63:0] d;
      logic g;
      d = {$urandom, $urandom};
      g = ($urandom % 32) != 0;
      step("R12 random", g, ($urandom % 3) != 0, d,
           N'($urandom & $urandom & $urandom), N'($urandom & $urandom),
           N'($urandom & $urandom & $urandom));
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule